// File: doc/BRIEF.md
# Packed Depth-Stencil Read-Modify-Write Unit

This block carries out single depth and stencil accesses on a buffer that packs a 24-bit depth value and an 8-bit stencil value into each 32-bit word. A client hands it one request at a time, with a word offset, an operation code and write data. The unit then runs the memory traffic that request needs on a single-port 32-bit memory with a request/acknowledge handshake. Writing one field is a read, a merge and a write back, and the merge leaves the other field of the word untouched. Reads mask out the field that was not asked for.

A mode input selects a 16-bit depth layout instead. In that layout the offset counts halfwords. Writes go straight to memory with two byte enables and are not merged, and reads return the addressed halfword. Requests are strictly serialized, so a write that follows a write to the same word always merges against the value the earlier write left behind. Address generation and depth comparison belong to the surrounding pipeline.

Top module: `ds_rmw_unit`

## Requirements
- R1: After reset the unit is idle: reqReady is 1 and busy, memReq and rspValid are 0.
- R2: reqOp bit 0 set means write and bit 1 set means stencil (00 read depth, 01 write depth, 10 read stencil, 11 write stencil). In 24/8 mode a depth read returns the addressed word with bits 31:24 cleared.
- R3: In 24/8 mode a stencil read returns word bits 31:24 in rspData bits 7:0, with all other bits 0.
- R4: In 24/8 mode a depth write reads the word, keeps bits 31:24, puts reqData bits 23:0 into bits 23:0 and writes the word back with all four byte enables set.
- R5: In 24/8 mode a stencil write reads the word, keeps bits 23:0, puts reqData bits 7:0 into bits 31:24 and writes the word back.
- R6: For every write the response carries rspData equal to 0.
- R7: With mode16 set, reqAddr is a halfword offset. The word address is reqAddr shifted right by one, and reqAddr bit 0 picks the upper half (1) or the lower half (0). A write issues one memory write, with no read, carrying reqData bits 15:0 in both halves and byte enables 1100 or 0011. A read returns the halfword zero-extended. Bit 1 of the operation has no effect in this mode.
- R8: When the memory acknowledges one cycle after each request, rspValid is high in the 3rd cycle after the accepting edge for a read or a 16-bit write, and in the 6th cycle for a merged write.
- R9: A request is accepted only while reqReady is high, and reqReady stays low from acceptance through the response cycle. Back-to-back writes to one word therefore merge against the earlier result.
- R10: busy is high from the accepting edge through the response cycle, and rspValid is a single-cycle pulse.
- R11: memReq, memWe and memAddr hold steady until memAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode16 | input | 1 | 1 selects the 16-bit depth layout, sampled on acceptance |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | Operation: bit 0 write, bit 1 stencil |
| reqAddr | input | ADDR_W | Word offset, or halfword offset in 16-bit mode |
| reqData | input | 32 | Write data, low bits used |
| reqReady | output | 1 | Unit can accept a request |
| busy | output | 1 | Request in progress |
| rspValid | output | 1 | Completion pulse |
| rspData | output | 32 | Read result, 0 for writes |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory word address |
| memBe | output | 4 | Byte enables for writes |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |

## Verification
A merge register loaded from the wrong lane, or a stale merge register, shows up as a wrong field in the next read of that word. That read comes within three cycles of the write's response, so the vector table interleaves writes and reads of the same word. A state machine that skips or repeats a phase changes the response latency, or the number of memory reads, right away in the same request. A wrong half-select in 16-bit mode corrupts the neighbouring halfword, and the following read of that half exposes it.

// File: rtl/ds_rmw_pkg.sv
package ds_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MERGE = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } rmw_state_e;

  typedef struct packed {
    logic latchReq;
    logic captureRead;
    logic doMerge;
  } rmw_strobe_t;
endpackage

// File: rtl/ds_rmw_ctrl.sv
module ds_rmw_ctrl
  import ds_rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        mode16,
  input  logic        opIsWrite,
  input  logic        memAck,
  output rmw_strobe_t strobe,
  output logic        reqReady,
  output logic        busy,
  output logic        rspValid,
  output logic        memReq,
  output logic        memWe
);
  rmw_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (reqValid) nextState = (reqWrite && mode16) ? ST_WRITE : ST_READ;
      ST_READ:  if (memAck) nextState = opIsWrite ? ST_MERGE : ST_DONE;
      ST_MERGE: nextState = ST_WRITE;
      ST_WRITE: if (memAck) nextState = ST_DONE;
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.latchReq    = (state == ST_IDLE) && reqValid;
    strobe.captureRead = (state == ST_READ) && memAck;
    strobe.doMerge     = (state == ST_MERGE);
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign memReq   = (state == ST_READ) || (state == ST_WRITE);
  assign memWe    = (state == ST_WRITE);
endmodule

// File: rtl/ds_rmw_datapath.sv
module ds_rmw_datapath
  import ds_rmw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEPTH_W   = 24,
  parameter int STENCIL_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rmw_strobe_t           strobe,
  input  logic                  mode16,
  input  logic [1:0]            reqOp,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DEPTH_W+STENCIL_W-1:0] reqData,
  input  logic [DEPTH_W+STENCIL_W-1:0] memRdata,
  output logic                  opIsWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [(DEPTH_W+STENCIL_W)/8-1:0] memBe,
  output logic [DEPTH_W+STENCIL_W-1:0] memWdata,
  output logic [DEPTH_W+STENCIL_W-1:0] rspData
);
  localparam int WORD_W = DEPTH_W + STENCIL_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int BE_W   = WORD_W / 8;
  localparam int HBE_W  = BE_W / 2;

  logic [1:0]        opReg;
  logic              m16Reg;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      m16Reg  <= 1'b0;
      addrReg <= '0;
      dataReg <= '0;
      wordReg <= '0;
    end else begin
      if (strobe.latchReq) begin
        opReg   <= reqOp;
        m16Reg  <= mode16;
        addrReg <= reqAddr;
        dataReg <= reqData;
        wordReg <= mode16 ? {2{reqData[HALF_W-1:0]}} : '0;
      end
      if (strobe.captureRead) wordReg <= memRdata;
      if (strobe.doMerge) begin
        if (opReg[1])
          wordReg <= {dataReg[STENCIL_W-1:0], wordReg[DEPTH_W-1:0]};
        else
          wordReg <= {wordReg[WORD_W-1:DEPTH_W], dataReg[DEPTH_W-1:0]};
      end
    end
  end

  assign opIsWrite = opReg[0];
  assign memAddr   = m16Reg ? (addrReg >> 1) : addrReg;
  assign memWdata  = wordReg;
  assign memBe     = m16Reg ? {{HBE_W{addrReg[0]}}, {HBE_W{~addrReg[0]}}} : {BE_W{1'b1}};

  always_comb begin
    rspData = '0;
    if (!opReg[0]) begin
      if (m16Reg)
        rspData[HALF_W-1:0] = addrReg[0] ? wordReg[WORD_W-1:HALF_W] : wordReg[HALF_W-1:0];
      else if (opReg[1])
        rspData[STENCIL_W-1:0] = wordReg[WORD_W-1:DEPTH_W];
      else
        rspData[DEPTH_W-1:0] = wordReg[DEPTH_W-1:0];
    end
  end
endmodule

// File: rtl/ds_rmw_unit.sv
module ds_rmw_unit
  import ds_rmw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEPTH_W   = 24,
  parameter int STENCIL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mode16,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DEPTH_W+STENCIL_W-1:0] reqData,
  output logic                 reqReady,
  output logic                 busy,
  output logic                 rspValid,
  output logic [DEPTH_W+STENCIL_W-1:0] rspData,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [(DEPTH_W+STENCIL_W)/8-1:0] memBe,
  output logic [DEPTH_W+STENCIL_W-1:0] memWdata,
  input  logic [DEPTH_W+STENCIL_W-1:0] memRdata,
  input  logic                 memAck
);
  rmw_strobe_t strobe;
  logic        opIsWrite;

  ds_rmw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqOp[0]),
    .mode16   (mode16),
    .opIsWrite(opIsWrite),
    .memAck   (memAck),
    .strobe   (strobe),
    .reqReady (reqReady),
    .busy     (busy),
    .rspValid (rspValid),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  ds_rmw_datapath #(
    .ADDR_W   (ADDR_W),
    .DEPTH_W  (DEPTH_W),
    .STENCIL_W(STENCIL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mode16   (mode16),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .memRdata (memRdata),
    .opIsWrite(opIsWrite),
    .memAddr  (memAddr),
    .memBe    (memBe),
    .memWdata (memWdata),
    .rspData  (rspData)
  );
endmodule

// File: rtl/ds_rmw_checker.sv
module ds_rmw_checker #(
  parameter int ADDR_W = 16,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busy,
  input logic              rspValid,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [BE_W-1:0]   memBe,
  input logic              memAck
);
  // R9: no acceptance while a request is in flight
  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  // R10: acceptance raises busy on the next cycle
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  // R10: response only while busy, and one cycle wide
  assert_rsp_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R11: request held steady until acknowledged
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R7: byte enables are whole word or one half
  assert_be_shape_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> ($countones(memBe) == BE_W || memBe == 4'b0011 || memBe == 4'b1100));
endmodule

bind ds_rmw_unit ds_rmw_checker #(.ADDR_W(ADDR_W), .BE_W((DEPTH_W+STENCIL_W)/8)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .busy    (busy),
  .rspValid(rspValid),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memBe   (memBe),
  .memAck  (memAck)
);

// File: tb/ds_rmw_unit_bench.sv
module ds_rmw_unit_bench;
  localparam int PERIOD = 10;
  localparam int AW = 16;

  typedef struct packed {
    logic        m16;
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  lat;
  } vec_t;

  // op: 0 read depth, 1 write depth, 2 read stencil, 3 write stencil
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'd3, 32'h0,        32'h00345678, 4'd3},
    '{1'b0, 2'd2, 8'd3, 32'h0,        32'h00000012, 4'd3},
    '{1'b0, 2'd1, 8'd3, 32'hFFABCDEF, 32'h0,        4'd6},
    '{1'b0, 2'd2, 8'd3, 32'h0,        32'h00000012, 4'd3},
    '{1'b0, 2'd0, 8'd3, 32'h0,        32'h00ABCDEF, 4'd3},
    '{1'b0, 2'd3, 8'd3, 32'h000001FE, 32'h0,        4'd6},
    '{1'b0, 2'd1, 8'd3, 32'h00000001, 32'h0,        4'd6},
    '{1'b0, 2'd0, 8'd3, 32'h0,        32'h00000001, 4'd3},
    '{1'b0, 2'd2, 8'd3, 32'h0,        32'h000000FE, 4'd3},
    '{1'b1, 2'd1, 8'd8, 32'h0000BEEF, 32'h0,        4'd3},
    '{1'b1, 2'd0, 8'd9, 32'h0,        32'h00001122, 4'd3},
    '{1'b1, 2'd0, 8'd8, 32'h0,        32'h0000BEEF, 4'd3},
    '{1'b1, 2'd3, 8'd9, 32'h0000CAFE, 32'h0,        4'd3},
    '{1'b1, 2'd2, 8'd9, 32'h0,        32'h0000CAFE, 4'd3},
    '{1'b0, 2'd0, 8'd4, 32'h0,        32'h00FEBEEF, 4'd3},
    '{1'b0, 2'd2, 8'd4, 32'h0,        32'h000000CA, 4'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mode16 = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic reqReady, busy, rspValid, memReq, memWe;
  logic [31:0] rspData, memWdata;
  logic [AW-1:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memRdata = '0;
  logic memAck = 1'b0;

  logic [31:0] mem [16];
  int readCount = 0;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  ds_rmw_unit #(.ADDR_W(AW)) u_ds_rmw_unit (
    .clk(clk), .rstN(rstN), .mode16(mode16), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady), .busy(busy),
    .rspValid(rspValid), .rspData(rspData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck)
  );

  // memory model: acknowledge one cycle after a request
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[3:0]][b*8 +: 8] <= memWdata[b*8 +: 8];
      end else begin
        memRdata <= mem[memAddr[3:0]];
        readCount <= readCount + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic m16, input logic [1:0] op, input logic [AW-1:0] addr,
                       input logic [31:0] data, output logic [31:0] rsp,
                       output int lat, output logic busyOk);
    @(negedge clk);
    mode16 = m16; reqOp = op; reqAddr = addr; reqData = data; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    busyOk = 1'b1;
    while (!rspValid && lat < 40) begin
      if (!busy || reqReady) busyOk = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (!busy || reqReady) busyOk = 1'b0;
    rsp = rspData;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rsp;
    int lat;
    logic busyOk;
    int readsBefore;

    for (int i = 0; i < 16; i++) mem[i] = 32'h01010101 * i;
    mem[3] = 32'h12345678;
    mem[4] = 32'h11223344;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reqReady", {31'b0, reqReady}, 32'd1);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 memReq", {31'b0, memReq}, 32'd0);
    check("R1 rspValid", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      readsBefore = readCount;
      runOp(VECS[v].m16, VECS[v].op, AW'(VECS[v].addr), VECS[v].data, rsp, lat, busyOk);
      // R2 R3 R4 R5 R6 R7 data; R8 latency; R9 R10 busy/ready
      check($sformatf("R2-data vec%0d", v), rsp, VECS[v].exp);
      check($sformatf("R8 latency vec%0d", v), 32'(lat), 32'(VECS[v].lat));
      check($sformatf("R10 busy vec%0d", v), {31'b0, busyOk}, 32'd1);
      if (VECS[v].m16 && VECS[v].op[0])
        check($sformatf("R7 no read vec%0d", v), 32'(readCount - readsBefore), 32'd0);
    end

    // R4 R5 R9 merged word state in memory
    check("R5 word3", mem[3], 32'hFE000001);
    check("R7 word4", mem[4], 32'hCAFEBEEF);
    check("R11 neighbour word5", mem[5], 32'h05050505);

    // R4 depth write on fresh word keeps stencil byte
    runOp(1'b0, 2'd1, 16'd6, 32'h00777777, rsp, lat, busyOk);
    check("R4 word6", mem[6], 32'h06777777);
    check("R6 write rsp", rsp, 32'h0);

    // R1 reset in mid-operation returns to idle
    @(negedge clk);
    mode16 = 1'b0; reqOp = 2'd1; reqAddr = 16'd7; reqData = 32'h1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid reset busy", {31'b0, busy}, 32'd0);
    check("R1 mid reset ready", {31'b0, reqReady}, 32'd1);
    check("R1 mid reset word7", mem[7], 32'h07070707);
    rstN = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule